// File: doc/BRIEF.md
# Two-Bank Interrupt Status Controller

This block gathers single-cycle event pulses into two 24-bit sticky status registers. Each status register has a companion 24-bit mask register. The block drives one active-high, level-sensitive interrupt request line to a host. The host reaches all four registers through a simple read/write port that takes a 6-bit register offset.

Interrupt numbers 0 to 23 belong to the low bank, and numbers 24 to 47 belong to the high bank at bit position (number minus 24). A status bit is set by its event and stays set until the host writes a one to it. A mask bit of one keeps its latched status bit from reaching the request line. At start-up every source is masked. A host unmasks only the sources it serves and acknowledges each one by writing it back. How events travel on the wire and what each event means are left to other blocks.

The request line comes from a two-state machine. The state is `REQ_QUIET` when no unmasked status bit is pending and `REQ_RAISED` when one is. The machine moves from `REQ_QUIET` to `REQ_RAISED` on the first clock edge that finds an unmasked pending bit. It moves from `REQ_RAISED` back to `REQ_QUIET` on the first edge that finds none. The line is high exactly while the state is `REQ_RAISED`.

Top module: `irq2b_ctrl`

## Requirements
- R1: Offset 0 holds low-bank status and offset 1 holds the low-bank mask. Offset 3 holds high-bank status and offset 4 holds the high-bank mask. A read with `rd_en` high loads `rd_data` at that clock edge. Any other offset reads zero, and a write to it changes nothing.
- R2: Event input `evt_lo_i[n]` is interrupt number n, and `evt_hi_i[n]` is interrupt number n+24. A pulse sets its status bit at the clock edge where it is sampled. The pulse affects only its own bank.
- R3: A mask bit of 1 keeps its pending status bit from raising `irq_req`. A mask bit of 0 lets it through.
- R4: Writing a 1 to a status bit clears it. Writing a 0 to a status bit leaves it unchanged.
- R5: `irq_req` rises on the clock edge after an unmasked pending bit first exists. It stays high while any such bit remains. It falls on the edge after none remains.
- R6: Low-bank bits 5, 17, 18 and 20 and high-bank bits 2 and 16 have no source. These bits never set, always read 0 and never raise `irq_req`.
- R7: After reset both mask registers read 0xFFFFFF.
- R8: After reset both status registers read 0 and `irq_req` is low.
- R9: When an event and a write-one-to-clear hit the same status bit in the same cycle, the bit stays set.
- R10: A masked event still latches its status bit. Clearing its mask bit raises `irq_req` on the following edge.
- R11: Bits 31 to 24 of every read are zero, whatever was written there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_lo_i | input | 24 | Event pulses for interrupt numbers 0 to 23 |
| evt_hi_i | input | 24 | Event pulses for interrupt numbers 24 to 47 |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| reg_addr | input | 6 | Register offset |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data, valid the cycle after `rd_en` |
| irq_req | output | 1 | Interrupt request to the host, active high |

## Verification
A wrong status or mask bit shows at the ports in two ways. It changes the next read of that bank, and it changes `irq_req` one edge after the fault appears. For example, a lost latch or a stuck mask bit leaves the line low after an unmask, and a wrong clear leaves the line high after an acknowledge. The bench reads back each bank after each masked event, acknowledge, zero write and unmapped write. It samples `irq_req` both in the cycle right after an event and in the cycle after that, so a wrong latency is caught as well as a wrong level. The same-cycle set-and-clear case and the bits that have no source are covered on their own.

// File: rtl/irq2b_pkg.sv
package irq2b_pkg;
    localparam int BANK_W_DEF = 24;
    localparam int ADDR_W_DEF = 6;
    localparam int DATA_W_DEF = 32;
    // bits that have an event source; 0 = no source, bit reads zero
    localparam logic [BANK_W_DEF-1:0] IMPL_LO_DEF = 24'hE9FFDF;
    localparam logic [BANK_W_DEF-1:0] IMPL_HI_DEF = 24'hFEFFFB;

    typedef enum logic [0:0] {
        REQ_QUIET  = 1'b0,
        REQ_RAISED = 1'b1
    } req_state_e;
endpackage

// File: rtl/irq2b_bank.sv
module irq2b_bank #(
    parameter int              W    = 24,
    parameter logic [W-1:0]    IMPL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt,
    input  logic         clr_we,
    input  logic         mask_we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] status,
    output logic [W-1:0] mask,
    output logic         pending
);
    logic [W-1:0] status_d;

    for (genvar i = 0; i < W; i++) begin : g_bit
        if (IMPL[i]) begin : g_src
            assign status_d[i] = evt[i] | (status[i] & ~(clr_we & wdata[i]));
        end else begin : g_nosrc
            assign status_d[i] = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) status <= '0;
        else        status <= status_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       mask <= '1;
        else if (mask_we) mask <= wdata;
    end

    assign pending = |(status & ~mask);

    // R6
    nosrc_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status & ~IMPL) == '0);

    // R2
    evt_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status & $past(evt & IMPL)) == $past(evt & IMPL)));

    // R4
    w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we |=> ((status & $past(wdata & ~evt)) == '0));

    // R4
    zero_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(status) & ~$past(clr_we ? wdata : '0) & ~status) == '0));

    // R1
    mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_we |=> $stable(mask));
endmodule

// File: rtl/irq2b_regport.sv
module irq2b_regport #(
    parameter int ADDR_W  = 6,
    parameter int DATA_W  = 32,
    parameter int W       = 24,
    parameter int OFF_S0  = 0,
    parameter int OFF_M0  = 1,
    parameter int OFF_S1  = 3,
    parameter int OFF_M1  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [W-1:0]      status0,
    input  logic [W-1:0]      mask0,
    input  logic [W-1:0]      status1,
    input  logic [W-1:0]      mask1,
    output logic [1:0]        clr_we,
    output logic [1:0]        mask_we,
    output logic [W-1:0]      wdata,
    output logic [DATA_W-1:0] rd_data
);
    localparam int PAD_W = DATA_W - W;

    logic [W-1:0] rd_sel;
    logic         unused_wr_hi;

    assign wdata        = wr_data[W-1:0];
    assign unused_wr_hi = ^wr_data[DATA_W-1:W];

    always_comb begin
        clr_we  = 2'b00;
        mask_we = 2'b00;
        if (wr_en) begin
            if (reg_addr == ADDR_W'(OFF_S0)) clr_we[0]  = 1'b1;
            if (reg_addr == ADDR_W'(OFF_M0)) mask_we[0] = 1'b1;
            if (reg_addr == ADDR_W'(OFF_S1)) clr_we[1]  = 1'b1;
            if (reg_addr == ADDR_W'(OFF_M1)) mask_we[1] = 1'b1;
        end
    end

    always_comb begin
        rd_sel = '0;
        if (reg_addr == ADDR_W'(OFF_S0)) rd_sel = status0;
        if (reg_addr == ADDR_W'(OFF_M0)) rd_sel = mask0;
        if (reg_addr == ADDR_W'(OFF_S1)) rd_sel = status1;
        if (reg_addr == ADDR_W'(OFF_M1)) rd_sel = mask1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= {{PAD_W{1'b0}}, rd_sel};
    end

    // R11
    upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[DATA_W-1:W] == '0);

    // R1
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));
endmodule

// File: rtl/irq2b_req_fsm.sv
module irq2b_req_fsm
    import irq2b_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pending_any,
    output logic irq_req
);
    req_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= REQ_QUIET;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            REQ_QUIET:  if (pending_any)  state_d = REQ_RAISED;
            REQ_RAISED: if (!pending_any) state_d = REQ_QUIET;
        endcase
    end

    always_comb begin
        irq_req = (state_q == REQ_RAISED);
    end

    // R5
    req_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_req) |-> $past(pending_any));

    // R5
    req_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_req) |-> !$past(pending_any));

    // R5
    req_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pending_any |=> irq_req);
endmodule

// File: rtl/irq2b_ctrl.sv
module irq2b_ctrl
    import irq2b_pkg::*;
#(
    parameter int                   BANK_W  = BANK_W_DEF,
    parameter int                   ADDR_W  = ADDR_W_DEF,
    parameter int                   DATA_W  = DATA_W_DEF,
    parameter logic [BANK_W-1:0]    IMPL_LO = IMPL_LO_DEF,
    parameter logic [BANK_W-1:0]    IMPL_HI = IMPL_HI_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BANK_W-1:0] evt_lo_i,
    input  logic [BANK_W-1:0] evt_hi_i,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq_req
);
    localparam int NBANK = 2;

    logic [NBANK-1:0][BANK_W-1:0] evt_arr;
    logic [NBANK-1:0][BANK_W-1:0] status_arr;
    logic [NBANK-1:0][BANK_W-1:0] mask_arr;
    logic [NBANK-1:0]             pend_arr;
    logic [NBANK-1:0]             clr_we;
    logic [NBANK-1:0]             mask_we;
    logic [BANK_W-1:0]            wdata;

    assign evt_arr = {evt_hi_i, evt_lo_i};

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        irq2b_bank #(
            .W    (BANK_W),
            .IMPL ((b == 0) ? IMPL_LO : IMPL_HI)
        ) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .evt     (evt_arr[b]),
            .clr_we  (clr_we[b]),
            .mask_we (mask_we[b]),
            .wdata   (wdata),
            .status  (status_arr[b]),
            .mask    (mask_arr[b]),
            .pending (pend_arr[b])
        );
    end

    irq2b_regport #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .W      (BANK_W)
    ) u_port (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .reg_addr (reg_addr),
        .wr_data  (wr_data),
        .status0  (status_arr[0]),
        .mask0    (mask_arr[0]),
        .status1  (status_arr[1]),
        .mask1    (mask_arr[1]),
        .clr_we   (clr_we),
        .mask_we  (mask_we),
        .wdata    (wdata),
        .rd_data  (rd_data)
    );

    irq2b_req_fsm u_req (
        .clk         (clk),
        .rst_n       (rst_n),
        .pending_any (|pend_arr),
        .irq_req     (irq_req)
    );

    // R3
    masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (((status_arr[0] & ~mask_arr[0]) == '0) && ((status_arr[1] & ~mask_arr[1]) == '0)
         && (evt_arr == '0) && !wr_en) |=> !irq_req);
endmodule

// File: tb/irq2b_ctrl_tb.sv
module irq2b_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] evt_lo_i = '0;
    logic [23:0] evt_hi_i = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        irq_req;

    int total = 0;
    int bad   = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #10 clk = ~clk;

    irq2b_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .evt_lo_i(evt_lo_i), .evt_hi_i(evt_hi_i),
        .wr_en(wr_en), .rd_en(rd_en), .reg_addr(reg_addr), .wr_data(wr_data),
        .rd_data(rd_data), .irq_req(irq_req)
    );

    task automatic check_val(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // monitor: pops expected read values as results appear
    initial begin
        forever begin
            @(posedge clk);
            if (rd_en) begin
                @(negedge clk);
                if (exp_q.size() == 0) check_val("R1 unexpected read", rd_data, 32'hx);
                else check_val(tag_q.pop_front(), rd_data, exp_q.pop_front());
            end
        end
    end

    task automatic rd(input logic [5:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        rd_en = 1'b1; reg_addr = a;
        exp_q.push_back(exp); tag_q.push_back(tag);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; reg_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse(input logic [23:0] lo, input logic [23:0] hi);
        @(negedge clk);
        evt_lo_i = lo; evt_hi_i = hi;
        @(negedge clk);
        evt_lo_i = '0; evt_hi_i = '0;
    endtask

    task automatic settle();
        @(negedge clk);
    endtask

    task automatic chk_irq(input logic exp, input string tag);
        check_val(tag, {31'd0, irq_req}, {31'd0, exp});
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        settle();
        // reset state
        chk_irq(1'b0, "R8 irq after reset");
        rd(6'd0, 32'h0,        "R8 status lo reset");
        rd(6'd1, 32'h00FFFFFF, "R7 mask lo reset");
        rd(6'd3, 32'h0,        "R8 status hi reset");
        rd(6'd4, 32'h00FFFFFF, "R7 mask hi reset");
        // masked event latches
        pulse(24'h000001, 24'h0); settle();
        chk_irq(1'b0, "R3 masked source quiet");
        rd(6'd0, 32'h1, "R10 latched while masked");
        // unmask pending source
        wr(6'd1, 32'h00FFFFFE);
        chk_irq(1'b0, "R5 irq one edge after unmask");
        settle();
        chk_irq(1'b1, "R10 unmask raises irq");
        rd(6'd1, 32'h00FFFFFE, "R1 mask lo readback");
        repeat (5) settle();
        chk_irq(1'b1, "R5 level held");
        // acknowledge
        wr(6'd0, 32'h1); settle();
        chk_irq(1'b0, "R5 irq drops after ack");
        rd(6'd0, 32'h0, "R4 w1c clears");
        // writing zero keeps
        pulse(24'h000006, 24'h0);
        wr(6'd0, 32'h0);
        rd(6'd0, 32'h6, "R4 zero write keeps");
        chk_irq(1'b0, "R3 masked bits 1,2 quiet");
        wr(6'd0, 32'h2);
        rd(6'd0, 32'h4, "R4 selective clear");
        wr(6'd0, 32'h00FFFFFF);
        // bits without a source
        pulse(24'hFFFFFF, 24'h0);
        rd(6'd0, 32'h00E9FFDF, "R6 lo unimplemented bits zero");
        rd(6'd3, 32'h0, "R2 lo events do not touch hi bank");
        wr(6'd0, 32'h00FFFFFF);
        rd(6'd0, 32'h0, "R4 full clear lo");
        pulse(24'h0, 24'hFFFFFF);
        rd(6'd3, 32'h00FEFFFB, "R6 hi unimplemented bits zero");
        rd(6'd0, 32'h0, "R2 hi events do not touch lo bank");
        wr(6'd3, 32'h00FFFFFF);
        rd(6'd3, 32'h0, "R4 full clear hi");
        // interrupt number 30 = hi bank bit 6
        pulse(24'h0, 24'h000040); settle();
        chk_irq(1'b0, "R3 hi masked quiet");
        wr(6'd4, 32'hAB_FFFFBF); settle();
        chk_irq(1'b1, "R2 number 30 raises irq");
        rd(6'd4, 32'h00FFFFBF, "R11 upper bits read zero");
        rd(6'd3, 32'h00000040, "R2 number 30 at hi bit 6");
        wr(6'd3, 32'h40); settle();
        chk_irq(1'b0, "R4 hi ack drops irq");
        // unmapped offsets
        wr(6'd2, 32'hFFFFFFFF);
        wr(6'd5, 32'h0);
        wr(6'd63, 32'h0);
        rd(6'd2,  32'h0, "R1 offset 2 reads zero");
        rd(6'd63, 32'h0, "R1 offset 63 reads zero");
        rd(6'd1, 32'h00FFFFFE, "R1 mask lo unchanged by unmapped write");
        rd(6'd4, 32'h00FFFFBF, "R1 mask hi unchanged by unmapped write");
        rd(6'd0, 32'h0, "R1 status lo unchanged by unmapped write");
        // same-cycle set and clear
        @(negedge clk);
        evt_lo_i = 24'h000001; wr_en = 1'b1; reg_addr = 6'd0; wr_data = 32'h1;
        @(negedge clk);
        evt_lo_i = '0; wr_en = 1'b0;
        settle();
        chk_irq(1'b1, "R9 set wins over clear irq");
        rd(6'd0, 32'h1, "R9 set wins over clear status");
        wr(6'd0, 32'h1); settle();
        chk_irq(1'b0, "R4 ack after collision");
        // unmask all; no-source bit cannot raise
        wr(6'd1, 32'h0);
        pulse(24'h000020, 24'h0); settle();
        chk_irq(1'b0, "R6 no-source bit never raises irq");
        // latency of an unmasked event
        pulse(24'h000008, 24'h0);
        chk_irq(1'b0, "R5 irq low in cycle after latch");
        settle();
        chk_irq(1'b1, "R5 irq high one edge later");
        wr(6'd0, 32'h8); settle();
        chk_irq(1'b0, "R5 irq low after final ack");
        repeat (3) settle();
        if (exp_q.size() != 0) check_val("R1 reads left unanswered", exp_q.size(), 0);
        finish_run();
    end
endmodule